// File: doc/BRIEF.md
# Streaming 128-Point Mixed-Radix FFT/IFFT Engine

This block turns a stream of complex baseband samples into frequency bins, 128 points per symbol, for an OFDM modem. Samples arrive four per clock on four parallel lanes, so a symbol takes 32 accepted beats. The bins leave the same way, four per clock in natural frequency order. Each output symbol carries a block exponent. The true bin value is the output word multiplied by two to the power of that exponent. A single mode input picks the forward or the inverse transform for each symbol.

The transform is split into three radix-4 passes and one final radix-2 pass. Each pass is a register stage that holds a whole symbol. The fixed twiddle factors are applied with constant shift-and-add multipliers. After every pass the stage finds the smallest right shift that brings every component of the symbol back into the data word. It applies that shift to the whole symbol and adds it to the running exponent. The inverse transform reuses the forward datapath: the real and imaginary parts are exchanged on the way in and again on the way out.

Top module: `ofdm_fft128`

## Requirements
- R1: With `in_inv` low, bin k (k = 0..127) of a symbol equals the sum over n of x[n]·e^(−j2πnk/128), represented as `out` word times 2^`out_exp`. The only error allowed is the error from word-length rounding: within 8·2^`out_exp` plus 1 % of the largest bin magnitude.
- R2: With the symbol's mode bit high, bin k equals the sum over n of x[n]·e^(+j2πnk/128), with no 1/128 factor, under the same tolerance as R1.
- R3: A symbol is 32 accepted beats (`in_valid` high). On beat c, lane l (bits l·W up to l·W+W−1 of `in_re`/`in_im`) carries sample 4c+l. Cycles with `in_valid` low are skipped and do not break the symbol.
- R4: A result leaves as 32 consecutive beats with `out_valid` high. On beat c, lane l carries bin 4c+l. `out_valid` falls only after a complete 32-beat run.
- R5: Each of the four passes shifts the whole symbol right arithmetically by the smallest amount from 0 to 4 that makes every real and imaginary part fit the signed W-bit word. `out_exp` is the sum of the four shifts. Two examples: a lone sample of 20000 at n = 0 gives exponent 0 and every bin equal to 20000+0j; 128 samples of 20000 give exponent 7, bin 0 equal to 20000 and all other bins 0.
- R6: The mode is taken from `in_inv` on the first beat of the symbol only. Its value on beats 1 to 31 has no effect.
- R7: The first bin beat of a symbol is present in the cycle after the fifth rising edge that follows the edge accepting the symbol's last beat. For a symbol without gaps, that is 36 edges after the edge accepting its first beat.
- R8: Symbols sent back to back, with no idle cycles, come out back to back with no idle cycles. `out_exp` holds one value over all 32 beats of a symbol.
- R9: While reset is asserted and after it is released, `out_valid` stays low until a full symbol has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_inv | input | 1 | Inverse transform when high; sampled on the first beat of a symbol |
| in_re | input | 4·DATA_W | Real parts of four samples, lane 0 in the low bits |
| in_im | input | 4·DATA_W | Imaginary parts of four samples, lane 0 in the low bits |
| out_valid | output | 1 | Output beat present |
| out_exp | output | 5 | Block exponent of the current output symbol |
| out_re | output | 4·DATA_W | Real parts of four bins, lane 0 in the low bits |
| out_im | output | 4·DATA_W | Imaginary parts of four bins, lane 0 in the low bits |

## Verification
The hardest situation to reach from the ports is a stage that has to shift by more than one bit while the neighbouring bins stay exact. The exponent would hide an error in that shift amount if only loose tolerances were checked. A full-scale constant symbol forces a shift of two in each radix-4 pass and a shift of one in the radix-2 pass, and every other bin cancels exactly. A lone sample checks the zero-shift path with exact values. Mode changes in the middle of a symbol, gaps in the middle of a symbol and back-to-back runs are mixed into the same stream, so that the alignment of the mode and the exponent with each result is checked under load.

// File: rtl/ofdm_fft128_pkg.sv
package ofdm_fft128_pkg;
  localparam int NPT      = 128;
  localparam int LANES    = 4;
  localparam int BEATS    = NPT / LANES;
  localparam int BEAT_W   = $clog2(BEATS);
  localparam int NSTG     = 4;
  localparam int GROW_MAX = 4;
  localparam int EXP_W    = $clog2(NSTG * GROW_MAX + 1);

  // sub-transform length handled by pass s
  function automatic int stg_len(input int s);
    int len;
    len = NPT;
    for (int t = 0; t < s; t++) len = len / 4;
    return len;
  endfunction

  // radix-4 passes first, radix-2 last
  function automatic int stg_rad(input int s);
    return (s < NSTG - 1) ? 4 : 2;
  endfunction

  // slot in the final pass holding bin k (mixed-radix digit reversal)
  function automatic int bin_slot(input int k);
    return (k % 4) * 32 + ((k / 4) % 4) * 8 + ((k / 16) % 4) * 2 + (k / 64);
  endfunction
endpackage

// File: rtl/ofdm_fft128_gather.sv
module ofdm_fft128_gather
  import ofdm_fft128_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_inv,
  input  logic signed [W-1:0] lane_re [LANES],
  input  logic signed [W-1:0] lane_im [LANES],
  output logic                sym_vld,
  output logic                sym_inv,
  output logic signed [W-1:0] sym_re [NPT],
  output logic signed [W-1:0] sym_im [NPT]
);
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              inv_q, inv_d, vld_d;

  always_comb begin
    beat_d = beat_q;
    inv_d  = inv_q;
    vld_d  = 1'b0;
    if (in_valid) begin
      beat_d = (beat_q == BEAT_W'(BEATS - 1)) ? '0 : beat_q + 1'b1;
      if (beat_q == '0) inv_d = in_inv;
      vld_d = (beat_q == BEAT_W'(BEATS - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      inv_q   <= 1'b0;
      sym_vld <= 1'b0;
    end else begin
      beat_q  <= beat_d;
      inv_q   <= inv_d;
      sym_vld <= vld_d;
    end
  end

  // parts exchanged on entry for the inverse transform
  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int l = 0; l < LANES; l++) begin
        sym_re[int'(beat_q) * LANES + l] <= inv_d ? lane_im[l] : lane_re[l];
        sym_im[int'(beat_q) * LANES + l] <= inv_d ? lane_re[l] : lane_im[l];
      end
    end
  end

  assign sym_inv = inv_q;
endmodule

// File: rtl/ofdm_fft128_stage.sv
module ofdm_fft128_stage
  import ofdm_fft128_pkg::*;
#(
  parameter int W   = 16,
  parameter int TW  = 12,
  parameter int LEN = 128,
  parameter int RAD = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic                in_inv,
  input  logic [EXP_W-1:0]    in_exp,
  input  logic signed [W-1:0] in_re [NPT],
  input  logic signed [W-1:0] in_im [NPT],
  output logic                out_vld,
  output logic                out_inv,
  output logic [EXP_W-1:0]    out_exp,
  output logic signed [W-1:0] out_re [NPT],
  output logic signed [W-1:0] out_im [NPT]
);
  localparam int  M  = LEN / RAD;
  localparam int  WI = W + GROW_MAX;
  localparam int  F  = TW - 2;
  localparam int  PW = WI + TW + 1;
  localparam real PI = 3.14159265358979;
  localparam logic signed [WI-1:0] HI = WI'(2 ** (W - 1) - 1);
  localparam logic signed [WI-1:0] LO = -WI'(2 ** (W - 1));

  logic signed [WI-1:0] wre [NPT];
  logic signed [WI-1:0] wim [NPT];
  int                   sh_c;

  // constant coefficient product built from shifted partial sums
  function automatic logic signed [PW-1:0] ksa(input logic signed [WI-1:0] x, input int k);
    logic signed [PW-1:0] acc, xs;
    int mag;
    acc = '0;
    xs  = PW'(x);
    mag = (k < 0) ? -k : k;
    for (int b = 0; b < TW; b++) if (mag[b]) acc = acc + (xs <<< b);
    return (k < 0) ? -acc : acc;
  endfunction

  function automatic int need(input logic signed [WI-1:0] v);
    for (int s = 0; s < GROW_MAX; s++)
      if ((v >>> s) <= HI && (v >>> s) >= LO) return s;
    return GROW_MAX;
  endfunction

  for (genvar i = 0; i < NPT; i++) begin : g_pt
    localparam int E    = i % LEN;
    localparam int Q    = E / M;
    localparam int J    = E % M;
    localparam int BASE = i - E;
    localparam int TP   = (J * Q) % LEN;
    logic signed [WI-1:0] sr, si;

    always_comb begin
      sr = '0;
      si = '0;
      for (int p = 0; p < RAD; p++) begin
        logic signed [WI-1:0] a, b;
        a = WI'(in_re[BASE + J + M * p]);
        b = WI'(in_im[BASE + J + M * p]);
        case ((p * Q * (4 / RAD)) % 4)
          0:       begin sr = sr + a; si = si + b; end
          1:       begin sr = sr + b; si = si - a; end
          2:       begin sr = sr - a; si = si - b; end
          default: begin sr = sr - b; si = si + a; end
        endcase
      end
    end

    if (TP == 0) begin : g_pass
      assign wre[i] = sr;
      assign wim[i] = si;
    end else begin : g_rot
      localparam real ANG = 2.0 * PI * real'(TP) / real'(LEN);
      localparam int  CC  = int'($cos(ANG) * (2.0 ** F));
      localparam int  SS  = int'($sin(ANG) * (2.0 ** F));
      logic signed [PW-1:0] pr, pq;
      assign pr     = ksa(sr, CC) + ksa(si, SS);
      assign pq     = ksa(si, CC) - ksa(sr, SS);
      assign wre[i] = WI'(pr >>> F);
      assign wim[i] = WI'(pq >>> F);
    end
  end

  // common shift for the whole symbol
  always_comb begin
    sh_c = 0;
    for (int i = 0; i < NPT; i++) begin
      if (need(wre[i]) > sh_c) sh_c = need(wre[i]);
      if (need(wim[i]) > sh_c) sh_c = need(wim[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_inv <= in_inv;
      out_exp <= in_exp + EXP_W'(sh_c);
      for (int i = 0; i < NPT; i++) begin
        out_re[i] <= W'(wre[i] >>> sh_c);
        out_im[i] <= W'(wim[i] >>> sh_c);
      end
    end
  end
endmodule

// File: rtl/ofdm_fft128_unload.sv
module ofdm_fft128_unload
  import ofdm_fft128_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_vld,
  input  logic                sym_inv,
  input  logic [EXP_W-1:0]    sym_exp,
  input  logic signed [W-1:0] sym_re [NPT],
  input  logic signed [W-1:0] sym_im [NPT],
  output logic                out_vld,
  output logic [EXP_W-1:0]    out_exp,
  output logic signed [W-1:0] lane_re [LANES],
  output logic signed [W-1:0] lane_im [LANES]
);
  logic [BEAT_W-1:0] rd_q, rd_d;
  logic              act_q, act_d, inv_h;
  logic signed [W-1:0] hold_re [NPT];
  logic signed [W-1:0] hold_im [NPT];

  always_comb begin
    rd_d  = rd_q;
    act_d = act_q;
    if (sym_vld) begin
      rd_d  = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      rd_d = rd_q + 1'b1;
      if (rd_q == BEAT_W'(BEATS - 1)) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      act_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (sym_vld) begin
      hold_re <= sym_re;
      hold_im <= sym_im;
      inv_h   <= sym_inv;
      out_exp <= sym_exp;
    end
  end

  // natural-order read of the digit-reversed symbol, parts exchanged back
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      int slot;
      slot = bin_slot(int'(rd_q) * LANES + l);
      lane_re[l] = inv_h ? hold_im[slot] : hold_re[slot];
      lane_im[l] = inv_h ? hold_re[slot] : hold_im[slot];
    end
  end

  assign out_vld = act_q;
endmodule

// File: rtl/ofdm_fft128.sv
module ofdm_fft128
  import ofdm_fft128_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TWID_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_inv,
  input  logic [LANES*DATA_W-1:0]   in_re,
  input  logic [LANES*DATA_W-1:0]   in_im,
  output logic                      out_valid,
  output logic [EXP_W-1:0]          out_exp,
  output logic [LANES*DATA_W-1:0]   out_re,
  output logic [LANES*DATA_W-1:0]   out_im
);
  logic signed [DATA_W-1:0] lre [LANES];
  logic signed [DATA_W-1:0] lim [LANES];
  logic signed [DATA_W-1:0] ore [LANES];
  logic signed [DATA_W-1:0] oim [LANES];
  logic signed [DATA_W-1:0] st_re [NSTG+1][NPT];
  logic signed [DATA_W-1:0] st_im [NSTG+1][NPT];
  logic                     st_vld [NSTG+1];
  logic                     st_inv [NSTG+1];
  logic [EXP_W-1:0]         st_exp [NSTG+1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lre[l] = in_re[l*DATA_W +: DATA_W];
    assign lim[l] = in_im[l*DATA_W +: DATA_W];
    assign out_re[l*DATA_W +: DATA_W] = ore[l];
    assign out_im[l*DATA_W +: DATA_W] = oim[l];
  end

  ofdm_fft128_gather #(.W(DATA_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inv(in_inv),
    .lane_re(lre), .lane_im(lim),
    .sym_vld(st_vld[0]), .sym_inv(st_inv[0]), .sym_re(st_re[0]), .sym_im(st_im[0])
  );
  assign st_exp[0] = '0;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    ofdm_fft128_stage #(
      .W(DATA_W), .TW(TWID_W), .LEN(stg_len(s)), .RAD(stg_rad(s))
    ) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_vld(st_vld[s]), .in_inv(st_inv[s]), .in_exp(st_exp[s]),
      .in_re(st_re[s]), .in_im(st_im[s]),
      .out_vld(st_vld[s+1]), .out_inv(st_inv[s+1]), .out_exp(st_exp[s+1]),
      .out_re(st_re[s+1]), .out_im(st_im[s+1])
    );
  end

  ofdm_fft128_unload #(.W(DATA_W)) u_unload (
    .clk(clk), .rst_n(rst_n),
    .sym_vld(st_vld[NSTG]), .sym_inv(st_inv[NSTG]), .sym_exp(st_exp[NSTG]),
    .sym_re(st_re[NSTG]), .sym_im(st_im[NSTG]),
    .out_vld(out_valid), .out_exp(out_exp), .lane_re(ore), .lane_im(oim)
  );
endmodule

// File: rtl/ofdm_fft128_chk.sv
module ofdm_fft128_chk
  import ofdm_fft128_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [EXP_W-1:0] out_exp
);
  logic [BEAT_W-1:0] ibeat, obeat;
  logic              in_done;

  assign in_done = in_valid && (ibeat == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibeat <= '0;
      obeat <= '0;
    end else begin
      if (in_valid)  ibeat <= ibeat + 1'b1;
      if (out_valid) obeat <= obeat + 1'b1;
    end
  end

  // R7: a result starts exactly six samples after its last input beat
  assert_first_bin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && obeat == '0) |-> $past(in_done, 6));
  assert_symbol_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_done, 6) |-> (out_valid && obeat == '0));
  // R4: output runs are whole symbols
  assert_whole_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> obeat == '0);
  // R8: one exponent per output symbol
  assert_exp_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && obeat != '0) |-> $stable(out_exp));
endmodule

bind ofdm_fft128 ofdm_fft128_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid), .out_exp(out_exp)
);

// File: tb/test_ofdm_fft128.sv
module test_ofdm_fft128;
  import ofdm_fft128_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int MAXSYM     = 16;
  localparam real PI        = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_inv, out_valid;
  logic [LANES*W-1:0] in_re, in_im, out_re, out_im;
  logic [EXP_W-1:0] out_exp;

  ofdm_fft128 #(.DATA_W(W), .TWID_W(12)) i_ofdm_fft128 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inv(in_inv),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_exp(out_exp),
    .out_re(out_re), .out_im(out_im)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0, n_bad = 0, n_sent = 0, n_seen = 0;
  bit  done = 0;
  real ref_re [MAXSYM][NPT];
  real ref_im [MAXSYM][NPT];
  int  first_cyc [MAXSYM];
  int  want_exp [MAXSYM];
  string tag [MAXSYM];
  int  xr [NPT];
  int  xi [NPT];

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // direct DFT; sign of the exponent picks forward or inverse
  task automatic build_ref(input int idx, input bit inv);
    for (int k = 0; k < NPT; k++) begin
      real sr, si, ang;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < NPT; n++) begin
        ang = 2.0 * PI * real'((n * k) % NPT) / real'(NPT) * (inv ? 1.0 : -1.0);
        sr += real'(xr[n]) * $cos(ang) - real'(xi[n]) * $sin(ang);
        si += real'(xr[n]) * $sin(ang) + real'(xi[n]) * $cos(ang);
      end
      ref_re[idx][k] = sr;
      ref_im[idx][k] = si;
    end
  endtask

  // junk_mode: drive the opposite mode on beats 1..31; gap_at: idle cycles before that beat
  task automatic send_sym(input bit inv, input bit junk_mode, input int gap_at,
                          input int wexp, input string t);
    int idx;
    idx = n_sent;
    build_ref(idx, inv);
    want_exp[idx] = wexp;
    tag[idx] = t;
    first_cyc[idx] = -1;
    n_sent++;
    for (int c = 0; c < BEATS; c++) begin
      if (c == gap_at) begin
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
      end
      for (int l = 0; l < LANES; l++) begin
        in_re[l*W +: W] = W'(xr[c*LANES + l]);
        in_im[l*W +: W] = W'(xi[c*LANES + l]);
      end
      in_inv   = (c == 0) ? inv : (junk_mode ? ~inv : inv);
      in_valid = 1'b1;
      @(negedge clk);
    end
    first_cyc[idx] = cyc + 5;  // R7: five edges after the last accepted beat
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic compare(input int idx, input real gr[NPT], input real gi[NPT], input int e);
    real scale, peak, tol, mag;
    scale = 2.0 ** e;
    peak = 0.0;
    for (int k = 0; k < NPT; k++) begin
      mag = $sqrt(ref_re[idx][k] ** 2 + ref_im[idx][k] ** 2);
      if (mag > peak) peak = mag;
    end
    if (want_exp[idx] >= 0) begin
      check(e == want_exp[idx], "R5", "block exponent", e, want_exp[idx]);
      tol = 0.5;  // exact cases
    end else begin
      tol = 8.0 * scale + 0.01 * peak;
    end
    for (int k = 0; k < NPT; k++) begin
      check((gr[k] * scale - ref_re[idx][k]) ** 2 <= tol * tol, tag[idx], $sformatf("bin %0d re", k),
            gr[k] * scale, ref_re[idx][k]);
      check((gi[k] * scale - ref_im[idx][k]) ** 2 <= tol * tol, tag[idx], $sformatf("bin %0d im", k),
            gi[k] * scale, ref_im[idx][k]);
    end
  endtask

  // output monitor
  initial begin
    int beat, e0, prevc;
    real gr [NPT];
    real gi [NPT];
    beat = 0; e0 = 0; prevc = 0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && out_valid === 1'b1) begin
        if (n_seen >= n_sent) begin
          check(1'b0, "R4", "unexpected output beat", n_seen, n_sent);
        end else begin
          if (beat == 0) begin
            e0 = int'(out_exp);
            check(cyc == first_cyc[n_seen], "R7", "first bin cycle", cyc, first_cyc[n_seen]);
          end else begin
            check(int'(out_exp) == e0, "R8", "exponent within symbol", out_exp, e0);
            check(cyc == prevc + 1, "R4", "consecutive beats", cyc, prevc + 1);
          end
          prevc = cyc;
          for (int l = 0; l < LANES; l++) begin
            gr[beat*LANES + l] = real'($signed(out_re[l*W +: W]));
            gi[beat*LANES + l] = real'($signed(out_im[l*W +: W]));
          end
          beat++;
          if (beat == BEATS) begin
            compare(n_seen, gr, gi, e0);
            n_seen++;
            beat = 0;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", cyc, 200000);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_inv = 1'b0; in_re = '0; in_im = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid during reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);

    // R5: lone sample, no shifting, all bins equal
    for (int n = 0; n < NPT; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 20000;
    send_sym(1'b0, 1'b0, -1, 0, "R5");
    idle(2);
    // R5: full-scale constant, shifts 2+2+2+1
    for (int n = 0; n < NPT; n++) begin xr[n] = 20000; xi[n] = 0; end
    send_sym(1'b0, 1'b0, -1, 7, "R5");
    idle(1);
    // R1: tone on bin 5
    for (int n = 0; n < NPT; n++) begin
      xr[n] = int'(1000.0 * $cos(2.0 * PI * 5.0 * n / 128.0));
      xi[n] = int'(1000.0 * $sin(2.0 * PI * 5.0 * n / 128.0));
    end
    send_sym(1'b0, 1'b0, -1, -1, "R1");
    // R8: random symbols back to back with the previous one
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < NPT; n++) begin
        xr[n] = int'($urandom_range(24000)) - 12000;
        xi[n] = int'($urandom_range(24000)) - 12000;
      end
      send_sym(1'b0, 1'b0, -1, -1, "R8");
    end
    // R3/R4: ramp makes lane or beat misordering visible
    for (int n = 0; n < NPT; n++) begin xr[n] = n * 100 - 6400; xi[n] = 3000 - n * 40; end
    send_sym(1'b0, 1'b0, -1, -1, "R4");
    idle(3);
    // R2: inverse tone and inverse random
    for (int n = 0; n < NPT; n++) begin
      xr[n] = int'(1500.0 * $cos(2.0 * PI * 9.0 * n / 128.0));
      xi[n] = int'(1500.0 * $sin(2.0 * PI * 9.0 * n / 128.0));
    end
    send_sym(1'b1, 1'b0, -1, -1, "R2");
    for (int n = 0; n < NPT; n++) begin
      xr[n] = int'($urandom_range(16000)) - 8000;
      xi[n] = int'($urandom_range(16000)) - 8000;
    end
    send_sym(1'b1, 1'b0, -1, -1, "R2");
    // R6: mode driven opposite on later beats, both directions
    send_sym(1'b1, 1'b1, -1, -1, "R6");
    send_sym(1'b0, 1'b1, -1, -1, "R6");
    idle(2);
    // R3: idle cycles inside a symbol
    for (int n = 0; n < NPT; n++) begin
      xr[n] = int'($urandom_range(20000)) - 10000;
      xi[n] = int'($urandom_range(20000)) - 10000;
    end
    send_sym(1'b0, 1'b0, 13, -1, "R3");
    idle(60);
    check(n_seen == n_sent, "R4", "symbols returned", n_seen, n_sent);
    check(out_valid == 1'b0, "R4", "idle after last symbol", out_valid, 0);
    finish_up();
  end
endmodule